// File: doc/BRIEF.md
# Event Timer Global Register Block

This block is the shared front end of a multi-channel event timer. It owns a free-running 32-bit main counter, a fixed capability word, a one-bit global enable and a per-channel interrupt status register. Software reaches all of them, and the per-channel registers of eight comparator channels, through a simple memory-mapped port that accepts 32-bit and 64-bit transfers.

Every request is checked for width and natural alignment. A legal 4-byte access picks one half of a 64-bit register by address bit 2. Accesses that decode to a channel register go out on a channel strobe bus that carries the channel index, a register code, the aligned write data and a byte-lane mask. A channel answers a read on the same cycle over a shared return bus. The channels raise their status bits through per-channel event inputs. Each status bit drives a level interrupt line that stays high until software writes a one to that bit.

The counter advances by one on each cycle with `tick_en` high while the global enable is set. The tick strobe is expected at 2^24 Hz, and the capability word reports the tick period derived from that rate.

Top module: `evt_timer_glb`

## Requirements
- R1: Only size codes 4 and 8 are accepted, and the address must be a multiple of the size. A write that fails this check changes no register and raises no channel strobe. A read that fails it returns zero.
- R2: A 4-byte access with address bit 2 set addresses bits 63:32 of the 64-bit register. A write changes only that half. A read returns that half in bits 31:0 with bits 63:32 zero. A 4-byte access with bit 2 clear returns bits 31:0 with the upper half zero.
- R3: The capability register at offset 0x000 reads 0x038D7EA4_1AB50701: revision 0x01 in bits 7:0, channel count minus one (7) in bits 12:8, zero in bit 13 (32-bit counter), vendor code 0x1AB5 in bits 31:16, and the tick period 10^15/2^24 fs (truncated) in bits 63:32. Writes to it are ignored.
- R4: The configuration register at offset 0x010 keeps only bit 0, the global enable, which is also driven on `cnt_run`. Every other bit reads as zero whatever is written.
- R5: While enabled, the main counter at offset 0x0F0 increases by one on each clock with `tick_en` high. While disabled, it holds its value.
- R6: A counter read returns the 32-bit value zero-extended to 64 bits. A write that covers bits 31:0 loads bits 31:0 of the data, even while the counter runs, and the load takes priority over a tick in the same cycle. The value is also driven on `cnt_val`.
- R7: Status bit n, at offset 0x020, is set by a pulse on `ch_evt[n]` and is driven on `irq_lvl[n]`. Writing to the register clears exactly the bits written as 1 in bits 7:0. An event in the same cycle as a clear leaves the bit set. Bits 63:32 read as zero and ignore writes.
- R8: Offsets 0x100 + 0x20·n + 0x08·k, for channel n from 0 to 7 and register code k (0 configuration, 1 comparator, 2 message route), are forwarded. A write pulses `ch_wr`, and a read pulses `ch_rd`. Both carry `ch_idx`=n and `ch_reg`=k, with `ch_wdata`/`ch_wmask` steered per R2. A read returns `ch_rdata`.
- R9: Any other offset, including register code 3 inside a channel window, reads as zero and has no effect on writes.
- R10: Each read request is answered on the following cycle with `bus_rvalid` high and the data on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick strobe |
| bus_valid | input | 1 | Request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 4 | Access width in bytes (4 or 8) |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 64 | Read response data |
| ch_evt | input | 8 | Per-channel interrupt event pulses |
| ch_wr | output | 1 | Channel register write strobe |
| ch_rd | output | 1 | Channel register read strobe |
| ch_idx | output | 3 | Addressed channel |
| ch_reg | output | 2 | Register code within the channel |
| ch_wdata | output | 64 | Write data aligned to the 64-bit register |
| ch_wmask | output | 64 | Bit mask of the half or halves written |
| ch_rdata | input | 64 | Read data from the addressed channel |
| irq_lvl | output | 8 | Level interrupt lines, one per channel |
| cnt_val | output | 32 | Current main counter value |
| cnt_run | output | 1 | Global enable |

## Verification
The assertions check several rules on every cycle: every read gets a response one cycle later, and a rejected read gets a zero response. A rejected request never strobes a channel, and the two channel strobes are never high together. The counter holds when it is stopped and steps by exactly one per tick when it is running, as long as no write intervenes. An interrupt line rises only after an event and falls only after a write. The directed scenarios cover what needs specific values: the capability constant, half-word steering in both directions, a counter load that collides with a tick, clear-versus-set priority in the status register, the forwarding of channel index and register code with their masks, and the zero responses from unmapped offsets.

// File: rtl/evt_glb_pkg.sv
package evt_glb_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_CFG,
        SEL_STS,
        SEL_CNT,
        SEL_CHAN
    } sel_e;

    localparam int unsigned OFF_CAP    = 32'h000;
    localparam int unsigned OFF_CFG    = 32'h010;
    localparam int unsigned OFF_STS    = 32'h020;
    localparam int unsigned OFF_CNT    = 32'h0F0;
    localparam int unsigned CH_BASE    = 32'h100;
    localparam int unsigned CH_STRIDE  = 32'h020;
endpackage

// File: rtl/evt_glb_decode.sv
module evt_glb_decode
    import evt_glb_pkg::*;
#(
    parameter int AW    = 12,
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [3:0]       bus_size,
    input  logic [AW-1:0]    bus_addr,
    input  logic [63:0]      bus_wdata,
    output logic             acc_ok,
    output logic             hi_half,
    output logic             size4,
    output sel_e             sel,
    output logic [IDX_W-1:0] idx,
    output logic [1:0]       rcode,
    output logic [63:0]      wmask,
    output logic [63:0]      wdata_al
);
    localparam int unsigned CH_SPAN = CH_STRIDE * N;

    logic          size8;
    logic [AW-1:0] base;
    logic [AW-1:0] off;
    logic          in_ch;

    always_comb begin
        size4   = (bus_size == 4'd4);
        size8   = (bus_size == 4'd8);
        acc_ok  = (size4 && bus_addr[1:0] == 2'b00) ||
                  (size8 && bus_addr[2:0] == 3'b000);
        hi_half = size4 && bus_addr[2];
        base    = {bus_addr[AW-1:3], 3'b000};
        off     = base - AW'(CH_BASE);
        idx     = off[5 +: IDX_W];
        rcode   = off[4:3];
        in_ch   = (base >= AW'(CH_BASE)) && (off < AW'(CH_SPAN)) &&
                  (off[4:3] != 2'b11);

        sel = SEL_NONE;
        if (acc_ok) begin
            if (base == AW'(OFF_CAP))      sel = SEL_CAP;
            else if (base == AW'(OFF_CFG)) sel = SEL_CFG;
            else if (base == AW'(OFF_STS)) sel = SEL_STS;
            else if (base == AW'(OFF_CNT)) sel = SEL_CNT;
            else if (in_ch)                sel = SEL_CHAN;
        end

        if (size8) begin
            wmask    = '1;
            wdata_al = bus_wdata;
        end else if (hi_half) begin
            wmask    = {32'hFFFF_FFFF, 32'h0};
            wdata_al = {bus_wdata[31:0], 32'h0};
        end else begin
            wmask    = {32'h0, 32'hFFFF_FFFF};
            wdata_al = {32'h0, bus_wdata[31:0]};
        end
    end
endmodule

// File: rtl/evt_glb_counter.sv
module evt_glb_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cfg_wr,
    input  logic          cfg_en,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_ld,
    output logic          run,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) st_d.run = cfg_en;
        if (cnt_wr)                   st_d.cnt = cnt_ld;
        else if (st_q.run && tick)    st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.run;
    assign cnt = st_q.cnt;
endmodule

// File: rtl/evt_glb_status.sv
module evt_glb_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] sts
);
    typedef struct packed {
        logic [N-1:0] sts;
    } sts_st_t;

    sts_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sts = (st_q.sts & ~clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
endmodule

// File: rtl/evt_timer_glb.sv
module evt_timer_glb
    import evt_glb_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          N         = 8,
    parameter int          CW        = 32,
    parameter int          TICK_LOG2 = 24,
    parameter logic [15:0] VENDOR_ID = 16'h1AB5,
    localparam int         IDX_W     = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             bus_valid,
    input  logic             bus_we,
    input  logic [3:0]       bus_size,
    input  logic [AW-1:0]    bus_addr,
    input  logic [63:0]      bus_wdata,
    output logic             bus_rvalid,
    output logic [63:0]      bus_rdata,
    input  logic [N-1:0]     ch_evt,
    output logic             ch_wr,
    output logic             ch_rd,
    output logic [IDX_W-1:0] ch_idx,
    output logic [1:0]       ch_reg,
    output logic [63:0]      ch_wdata,
    output logic [63:0]      ch_wmask,
    input  logic [63:0]      ch_rdata,
    output logic [N-1:0]     irq_lvl,
    output logic [CW-1:0]    cnt_val,
    output logic             cnt_run
);
    localparam logic [63:0] PERIOD_FS = 64'd1000000000000000 >> TICK_LOG2;
    localparam logic [63:0] CAPS = {PERIOD_FS[31:0], VENDOR_ID, 3'b000,
                                    5'(N - 1), 8'h01};

    typedef struct packed {
        logic        valid;
        logic [63:0] data;
    } rsp_t;

    logic        acc_ok, hi_half, size4, wr_go;
    sel_e        sel;
    logic [63:0] wmask, wdata_al, rd_raw;
    logic [N-1:0] clr;
    rsp_t        rsp_d, rsp_q;

    evt_glb_decode #(.AW(AW), .N(N), .IDX_W(IDX_W)) u_dec (
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .acc_ok   (acc_ok),
        .hi_half  (hi_half),
        .size4    (size4),
        .sel      (sel),
        .idx      (ch_idx),
        .rcode    (ch_reg),
        .wmask    (wmask),
        .wdata_al (wdata_al)
    );

    assign wr_go = bus_valid && bus_we;

    evt_glb_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .cfg_wr(wr_go && sel == SEL_CFG && wmask[0]),
        .cfg_en(wdata_al[0]),
        .cnt_wr(wr_go && sel == SEL_CNT && wmask[0]),
        .cnt_ld(wdata_al[CW-1:0]),
        .run   (cnt_run),
        .cnt   (cnt_val)
    );

    assign clr = (wr_go && sel == SEL_STS && wmask[0]) ? wdata_al[N-1:0] : '0;

    evt_glb_status #(.N(N)) u_sts (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (ch_evt),
        .clr  (clr),
        .sts  (irq_lvl)
    );

    assign ch_wr    = wr_go && sel == SEL_CHAN;
    assign ch_rd    = bus_valid && !bus_we && sel == SEL_CHAN;
    assign ch_wdata = wdata_al;
    assign ch_wmask = wmask;

    always_comb begin
        unique case (sel)
            SEL_CAP:  rd_raw = CAPS;
            SEL_CFG:  rd_raw = {63'h0, cnt_run};
            SEL_STS:  rd_raw = {{(64-N){1'b0}}, irq_lvl};
            SEL_CNT:  rd_raw = {{(64-CW){1'b0}}, cnt_val};
            SEL_CHAN: rd_raw = ch_rdata;
            default:  rd_raw = '0;
        endcase

        rsp_d.valid = bus_valid && !bus_we;
        if (!acc_ok)      rsp_d.data = '0;
        else if (hi_half) rsp_d.data = {32'h0, rd_raw[63:32]};
        else if (size4)   rsp_d.data = {32'h0, rd_raw[31:0]};
        else              rsp_d.data = rd_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rvalid = rsp_q.valid;
    assign bus_rdata  = rsp_q.data;
endmodule

// File: rtl/evt_glb_checker.sv
module evt_glb_checker #(
    parameter int AW = 12,
    parameter int N  = 8,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          bus_valid,
    input logic          bus_we,
    input logic [3:0]    bus_size,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rvalid,
    input logic [63:0]   bus_rdata,
    input logic [N-1:0]  ch_evt,
    input logic          ch_wr,
    input logic          ch_rd,
    input logic [N-1:0]  irq_lvl,
    input logic [CW-1:0] cnt_val,
    input logic          cnt_run
);
    logic legal, any_wr;
    assign legal  = (bus_size == 4'd4 && bus_addr[1:0] == 2'b00) ||
                    (bus_size == 4'd8 && bus_addr[2:0] == 3'b000);
    assign any_wr = bus_valid && bus_we;

    AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_we |=> bus_rvalid); // R10

    AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_we && !legal |=> bus_rdata == 64'h0); // R1

    AST_BAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !legal |-> !ch_wr && !ch_rd); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_wr, ch_rd})); // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_run && !any_wr |=> $stable(cnt_val)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_run && tick_en && !any_wr |=> cnt_val == $past(cnt_val) + 1'b1); // R5

    AST_IRQ_RISE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_lvl & ~$past(irq_lvl) & ~$past(ch_evt)) == '0); // R7

    AST_IRQ_FALL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> ($past(irq_lvl) & ~irq_lvl) == '0); // R7
endmodule

bind evt_timer_glb evt_glb_checker #(.AW(AW), .N(N), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_rvalid(bus_rvalid),
    .bus_rdata (bus_rdata),
    .ch_evt    (ch_evt),
    .ch_wr     (ch_wr),
    .ch_rd     (ch_rd),
    .irq_lvl   (irq_lvl),
    .cnt_val   (cnt_val),
    .cnt_run   (cnt_run)
);

// File: tb/tb_evt_timer_glb.sv
module tb_evt_timer_glb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_size = 4'd8;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [63:0] bus_rdata;
    logic [7:0]  ch_evt = '0;
    logic        ch_wr, ch_rd;
    logic [2:0]  ch_idx;
    logic [1:0]  ch_reg;
    logic [63:0] ch_wdata, ch_wmask, ch_rdata;
    logic [7:0]  irq_lvl;
    logic [31:0] cnt_val;
    logic        cnt_run;

    int n_run = 0;
    int n_fail = 0;
    int wr_seen = 0;
    logic [2:0]  last_idx;
    logic [1:0]  last_reg;
    logic [63:0] last_data, last_mask;

    always #5 clk = ~clk;

    assign ch_rdata = {32'hCAFE0000 | 32'({ch_idx, ch_reg}),
                       32'h12340000 | 32'({ch_reg, ch_idx})};

    evt_timer_glb dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .ch_evt(ch_evt), .ch_wr(ch_wr), .ch_rd(ch_rd),
        .ch_idx(ch_idx), .ch_reg(ch_reg), .ch_wdata(ch_wdata),
        .ch_wmask(ch_wmask), .ch_rdata(ch_rdata),
        .irq_lvl(irq_lvl), .cnt_val(cnt_val), .cnt_run(cnt_run)
    );

    always @(posedge clk) begin
        if (ch_wr) begin
            wr_seen   <= wr_seen + 1;
            last_idx  <= ch_idx;
            last_reg  <= ch_reg;
            last_data <= ch_wdata;
            last_mask <= ch_wmask;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] sz,
                      input logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_size = sz;
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] sz,
                      output logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_size = sz; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R10", "rvalid", 64'(bus_rvalid), 64'h1);
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(12'h010, 4'd8, v); chk("R4", "cfg after reset", v, 64'h0);
        rd(12'h0F0, 4'd8, v); chk("R6", "cnt after reset", v, 64'h0);
        rd(12'h020, 4'd8, v); chk("R7", "sts after reset", v, 64'h0);
        chk("R7", "irq after reset", 64'(irq_lvl), 64'h0);
    endtask

    task automatic t_caps();
        logic [63:0] v;
        rd(12'h000, 4'd8, v); chk("R3", "caps", v, 64'h038D7EA4_1AB50701);
        rd(12'h004, 4'd4, v); chk("R2", "caps hi half", v, 64'h038D7EA4);
        rd(12'h000, 4'd4, v); chk("R2", "caps lo half", v, 64'h1AB50701);
        wr(12'h000, 4'd8, '1);
        rd(12'h000, 4'd8, v); chk("R3", "caps after write", v, 64'h038D7EA4_1AB50701);
    endtask

    task automatic t_cfg();
        logic [63:0] v;
        wr(12'h010, 4'd8, '1);
        rd(12'h010, 4'd8, v); chk("R4", "cfg only bit0", v, 64'h1);
        chk("R4", "cnt_run", 64'(cnt_run), 64'h1);
        wr(12'h014, 4'd4, 32'h0);
        rd(12'h010, 4'd8, v); chk("R2", "cfg hi write keeps enable", v, 64'h1);
    endtask

    task automatic t_counter();
        logic [63:0] v;
        wr(12'h0F0, 4'd8, 64'hFFFF_FFFF_0000_0010);
        rd(12'h0F0, 4'd8, v); chk("R6", "load zero-extended", v, 64'h10);
        @(negedge clk); tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd(12'h0F0, 4'd8, v); chk("R5", "5 ticks", v, 64'h15);
        wr(12'h010, 4'd8, 64'h0);
        @(negedge clk); tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        rd(12'h0F0, 4'd8, v); chk("R5", "hold when disabled", v, 64'h15);
        wr(12'h0F4, 4'd4, 64'h1234);
        rd(12'h0F0, 4'd8, v); chk("R2", "cnt hi write no effect", v, 64'h15);
        rd(12'h0F0, 4'd4, v); chk("R2", "cnt lo 4B read", v, 64'h15);
        wr(12'h010, 4'd8, 64'h1);
        @(negedge clk);
        tick_en = 1'b1; bus_valid = 1'b1; bus_we = 1'b1; bus_size = 4'd8;
        bus_addr = 12'h0F0; bus_wdata = 64'h100;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        chk("R6", "load beats tick", 64'(cnt_val), 64'h100);
        @(negedge clk);
        tick_en = 1'b0;
        chk("R5", "tick after load", 64'(cnt_val), 64'h101);
    endtask

    task automatic t_status();
        logic [63:0] v;
        @(negedge clk); ch_evt = 8'hA5;
        @(negedge clk); ch_evt = 8'h00;
        chk("R7", "irq set", 64'(irq_lvl), 64'hA5);
        rd(12'h020, 4'd8, v); chk("R7", "sts read", v, 64'hA5);
        wr(12'h020, 4'd8, 64'h03);
        rd(12'h020, 4'd8, v); chk("R7", "w1c partial", v, 64'hA4);
        wr(12'h024, 4'd4, 64'hFF);
        rd(12'h020, 4'd8, v); chk("R7", "hi half no clear", v, 64'hA4);
        wr(12'h020, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7", "all cleared", 64'(irq_lvl), 64'h0);
        @(negedge clk);
        ch_evt = 8'h01; bus_valid = 1'b1; bus_we = 1'b1; bus_size = 4'd8;
        bus_addr = 12'h020; bus_wdata = 64'h01;
        @(negedge clk);
        ch_evt = 8'h00; bus_valid = 1'b0; bus_we = 1'b0;
        chk("R7", "set wins over clear", 64'(irq_lvl), 64'h01);
        wr(12'h020, 4'd8, 64'h01);
    endtask

    task automatic t_align();
        logic [63:0] v;
        int w0;
        wr(12'h010, 4'd8, 64'h0);
        wr(12'h012, 4'd4, 64'h1);
        wr(12'h014, 4'd8, 64'h1);
        wr(12'h010, 4'd2, 64'h1);
        chk("R1", "bad writes ignored", 64'(cnt_run), 64'h0);
        rd(12'h004, 4'd8, v); chk("R1", "misaligned 8B read", v, 64'h0);
        rd(12'h002, 4'd4, v); chk("R1", "misaligned 4B read", v, 64'h0);
        rd(12'h000, 4'd1, v); chk("R1", "bad size read", v, 64'h0);
        w0 = wr_seen;
        wr(12'h104, 4'd8, '1);
        chk("R1", "no strobe on misaligned", 64'(wr_seen - w0), 64'h0);
    endtask

    task automatic t_chan();
        logic [63:0] v;
        int w0;
        w0 = wr_seen;
        wr(12'h1A8, 4'd8, 64'hDEAD_BEEF_0123_4567);
        chk("R8", "write strobe", 64'(wr_seen - w0), 64'h1);
        chk("R8", "idx", 64'(last_idx), 64'h5);
        chk("R8", "reg", 64'(last_reg), 64'h1);
        chk("R8", "mask", last_mask, '1);
        chk("R8", "data", last_data, 64'hDEAD_BEEF_0123_4567);
        wr(12'h154, 4'd4, 64'h89AB_CDEF);
        chk("R8", "hi idx/reg", 64'({last_idx, last_reg}), 64'({3'd2, 2'd2}));
        chk("R2", "hi mask", last_mask, 64'hFFFF_FFFF_0000_0000);
        chk("R2", "hi data", last_data, 64'h89AB_CDEF_0000_0000);
        rd(12'h1E0, 4'd8, v); chk("R8", "read ch7 cfg", v, 64'hCAFE001C_12340007);
        rd(12'h16C, 4'd4, v); chk("R2", "read ch3 cmp hi", v, 64'hCAFE000D);
    endtask

    task automatic t_unmapped();
        logic [63:0] v;
        int w0;
        rd(12'h030, 4'd8, v); chk("R9", "gap read", v, 64'h0);
        rd(12'h0F8, 4'd8, v); chk("R9", "0xF8 read", v, 64'h0);
        rd(12'h118, 4'd8, v); chk("R9", "chan code 3 read", v, 64'h0);
        rd(12'h200, 4'd8, v); chk("R9", "past last chan", v, 64'h0);
        w0 = wr_seen;
        wr(12'h118, 4'd8, '1);
        wr(12'h200, 4'd8, '1);
        chk("R9", "no strobe unmapped", 64'(wr_seen - w0), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_caps();
        t_cfg();
        t_counter();
        t_status();
        t_align();
        t_chan();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule